// File: doc/BRIEF.md
# Soft Mute Attenuation Ramp Controller

This block keeps an 8-bit attenuation setting for each of the two audio channels and turns those settings into the gain codes that the audio datapath multiplies by. A gain code of 0xFF means unity gain (0 dB). Each lower code adds 0.5 dB of attenuation, so a code X from 1 to 255 gives 0.5·(X−255) dB, and code 0x00 silences the channel. Software writes each channel's value into a holding register. A write that carries the load flag copies both held values into the active settings in the same clock cycle, so a stereo balance change reaches both channels together. An optional common mode drives both channels from the left channel's active setting.

The gain never jumps. It moves one code toward its target once every `STEP_PERIOD` sample ticks. Soft mute can come from an active-low pin or from a control bit. Mute sets the target to 0x00 and leaves the stored settings untouched. Releasing mute ramps the gain back up to those stored settings. If the target changes partway through a ramp, the gain turns and heads for the new target from wherever it is. A separate zero-run detector counts consecutive samples that are zero on both channels. When that detector is enabled and the count reaches `ZERO_RUN`, it raises an automute flag for the analogue stage. This flag never touches the digital gain.

Top module: `soft_atten_ctrl`

## Requirements
- R1: After reset, both gain outputs are 0xFF and `auto_mute` is 0. Both holding registers and both active settings reset to 0xFF.
- R2: A write with `wr_load`=0 only updates the holding register picked by `wr_sel` (0 = left, 1 = right). Neither gain output moves on any later tick.
- R3: A write with `wr_load`=1 first stores its value and then copies both holding registers into the active settings at the same time. Both channels then ramp toward their new values.
- R4: While `common_en`=1, the right gain follows the left active setting, and the right active setting has no effect on the right gain.
- R5: While a gain differs from its target, it changes by exactly one code on every `STEP_PERIOD`-th sample tick. The first step comes on the `STEP_PERIOD`-th tick after the difference appears. A gain never changes in a cycle without a tick.
- R6: Mute is active when `mute_n`=0 or `mute_bit`=1. Mute ramps both gains down to 0x00 (silence) and holds them there.
- R7: When mute is released, both gains ramp back up to the stored active settings, which mute did not alter.
- R8: If the target changes during a ramp, the gain reverses from its current value. The next step comes `STEP_PERIOD` ticks after the previous step.
- R9: With `zdet_en`=1, `auto_mute` rises after `ZERO_RUN` consecutive ticks on which `zero_l` and `zero_r` are both 1. A tick on which only one channel is zero does not count toward that run. With `zdet_en`=0, `auto_mute` stays 0.
- R10: The first tick that carries a non-zero sample on either channel clears `auto_mute`.
- R11: Automute has no effect on the gain outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| fs_tick | input | 1 | One-cycle pulse, once per sample period |
| wr_en | input | 1 | Attenuation write strobe |
| wr_sel | input | 1 | Channel selected for the write: 0 = left, 1 = right |
| wr_load | input | 1 | Copies both holding registers into the active settings |
| wr_code | input | 8 | Attenuation code to write |
| common_en | input | 1 | Drives both channels from the left active setting |
| mute_n | input | 1 | Soft mute pin, active low |
| mute_bit | input | 1 | Soft mute control bit, active high |
| zdet_en | input | 1 | Enables the zero-run automute |
| zero_l | input | 1 | Left sample at this tick is zero |
| zero_r | input | 1 | Right sample at this tick is zero |
| gain_l | output | 8 | Effective left gain code |
| gain_r | output | 8 | Effective right gain code |
| auto_mute | output | 1 | Automute flag for the analogue stage |

## Verification
Each channel holds its state in three registers: the holding register, the active setting and the ramp counter. A wrong holding register or active setting stays hidden until a load write or a mute release steers a gain toward it. The error then shows as a wrong final gain after the ramp settles, one `STEP_PERIOD` per code of error. A wrong ramp counter moves the first step off its expected tick, so the bench checks the gain on the tick just before and the tick of each expected step. A wrong zero-run count shows as `auto_mute` rising one tick early or late around the `ZERO_RUN`-th zero sample.

// File: rtl/soft_atten_pkg.sv
package soft_atten_pkg;
  localparam int CODE_W = 8;
  localparam int NCH    = 2;
  localparam int CH_L   = 0;
  localparam int CH_R   = 1;

  typedef logic [CODE_W-1:0] code_t;

  localparam code_t CODE_UNITY = {CODE_W{1'b1}};
  localparam code_t CODE_SILENT = '0;
endpackage

// File: rtl/atten_bank.sv
module atten_bank
  import soft_atten_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  logic  wr_sel,
  input  logic  wr_load,
  input  code_t wr_code,
  input  logic  common_en,
  input  logic  muted,
  output code_t tgt_l,
  output code_t tgt_r
);

  logic [NCH-1:0][CODE_W-1:0] hold_q, hold_d;
  logic [NCH-1:0][CODE_W-1:0] act_q, act_d;

  // next-state: hold register written first, load copies both
  always_comb begin
    hold_d = hold_q;
    act_d  = act_q;
    hold_d[wr_sel] = wr_code;
    if (wr_load) act_d = hold_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= {NCH{CODE_UNITY}};
      act_q  <= {NCH{CODE_UNITY}};
    end else if (wr_en) begin
      hold_q <= hold_d;
      act_q  <= act_d;
    end
  end

  always_comb begin
    tgt_l = muted ? CODE_SILENT : code_t'(act_q[CH_L]);
    tgt_r = muted ? CODE_SILENT :
            (common_en ? code_t'(act_q[CH_L]) : code_t'(act_q[CH_R]));
  end

endmodule

// File: rtl/gain_stepper.sv
module gain_stepper
  import soft_atten_pkg::*;
#(
  parameter int STEP_PERIOD = 128
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  fs_tick,
  input  code_t tgt,
  output code_t gain
);

  localparam int CW = (STEP_PERIOD > 2) ? $clog2(STEP_PERIOD) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(STEP_PERIOD - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  code_t         gain_q, gain_d;
  logic          run_en;

  assign run_en = (gain_q != tgt) ? fs_tick : 1'b1;

  always_comb begin
    cnt_d  = cnt_q;
    gain_d = gain_q;
    if (gain_q == tgt) begin
      cnt_d = '0;
    end else if (cnt_q == CNT_LAST) begin
      cnt_d  = '0;
      gain_d = (gain_q < tgt) ? gain_q + code_t'(1) : gain_q - code_t'(1);
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      gain_q <= CODE_UNITY;
    end else if (run_en) begin
      cnt_q  <= cnt_d;
      gain_q <= gain_d;
    end
  end

  assign gain = gain_q;

endmodule

// File: rtl/zero_run_det.sv
module zero_run_det #(
  parameter int ZERO_RUN = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fs_tick,
  input  logic zero_l,
  input  logic zero_r,
  input  logic zdet_en,
  output logic flag
);

  localparam int CW = $clog2(ZERO_RUN + 1);
  localparam logic [CW-1:0] RUN_FULL = CW'(ZERO_RUN);

  logic [CW-1:0] run_q, run_d;
  logic          full;

  assign full = (run_q == RUN_FULL);

  always_comb begin
    if (!(zero_l && zero_r)) run_d = '0;
    else if (full)           run_d = run_q;
    else                     run_d = run_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_q <= '0;
    else if (fs_tick) run_q <= run_d;
  end

  assign flag = zdet_en && full;

endmodule

// File: rtl/soft_atten_ctrl.sv
module soft_atten_ctrl
  import soft_atten_pkg::*;
#(
  parameter int STEP_PERIOD = 128,
  parameter int ZERO_RUN    = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fs_tick,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic       wr_load,
  input  logic [7:0] wr_code,
  input  logic       common_en,
  input  logic       mute_n,
  input  logic       mute_bit,
  input  logic       zdet_en,
  input  logic       zero_l,
  input  logic       zero_r,
  output logic [7:0] gain_l,
  output logic [7:0] gain_r,
  output logic       auto_mute
);

  logic [1:0] rst_sync_q;
  logic       srst_n;
  logic       muted;
  logic [NCH-1:0][CODE_W-1:0] tgt_v;
  logic [NCH-1:0][CODE_W-1:0] gain_v;
  code_t      tgt_l, tgt_r;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  assign muted = !mute_n || mute_bit;

  atten_bank u_bank (
    .clk       (clk),
    .rst_n     (srst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_load   (wr_load),
    .wr_code   (wr_code),
    .common_en (common_en),
    .muted     (muted),
    .tgt_l     (tgt_l),
    .tgt_r     (tgt_r)
  );

  assign tgt_v[CH_L] = tgt_l;
  assign tgt_v[CH_R] = tgt_r;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    gain_stepper #(.STEP_PERIOD(STEP_PERIOD)) u_step (
      .clk     (clk),
      .rst_n   (srst_n),
      .fs_tick (fs_tick),
      .tgt     (tgt_v[c]),
      .gain    (gain_v[c])
    );
  end

  zero_run_det #(.ZERO_RUN(ZERO_RUN)) u_zero (
    .clk     (clk),
    .rst_n   (srst_n),
    .fs_tick (fs_tick),
    .zero_l  (zero_l),
    .zero_r  (zero_r),
    .zdet_en (zdet_en),
    .flag    (auto_mute)
  );

  assign gain_l = gain_v[CH_L];
  assign gain_r = gain_v[CH_R];

endmodule

// File: rtl/soft_atten_ctrl_chk.sv
module soft_atten_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fs_tick,
  input logic       mute_n,
  input logic       mute_bit,
  input logic       zdet_en,
  input logic       zero_l,
  input logic       zero_r,
  input logic [7:0] gain_l,
  input logic [7:0] gain_r,
  input logic       auto_mute
);

  // R5
  left_tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_l != $past(gain_l)) |-> $past(fs_tick));

  // R5
  right_tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_r != $past(gain_r)) |-> $past(fs_tick));

  // R5
  left_unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_l != $past(gain_l)) |->
      (gain_l == $past(gain_l) + 8'd1 || gain_l == $past(gain_l) - 8'd1));

  // R5
  right_unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_r != $past(gain_r)) |->
      (gain_r == $past(gain_r) + 8'd1 || gain_r == $past(gain_r) - 8'd1));

  // R6
  left_mute_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!mute_n || mute_bit) && gain_l == 8'h00) |=> (gain_l == 8'h00));

  // R6
  right_mute_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!mute_n || mute_bit) && gain_r == 8'h00) |=> (gain_r == 8'h00));

  // R9
  automute_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(auto_mute) && $past(zdet_en)) |-> $past(fs_tick && zero_l && zero_r));

endmodule

bind soft_atten_ctrl soft_atten_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fs_tick   (fs_tick),
  .mute_n    (mute_n),
  .mute_bit  (mute_bit),
  .zdet_en   (zdet_en),
  .zero_l    (zero_l),
  .zero_r    (zero_r),
  .gain_l    (gain_l),
  .gain_r    (gain_r),
  .auto_mute (auto_mute)
);

// File: tb/soft_atten_ctrl_test.sv
module soft_atten_ctrl_test;
  localparam int STEP = 4;
  localparam int RUN  = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       fs_tick, wr_en, wr_sel, wr_load;
  logic [7:0] wr_code;
  logic       common_en, mute_n, mute_bit, zdet_en, zero_l, zero_r;
  logic [7:0] gain_l, gain_r;
  logic       auto_mute;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  soft_atten_ctrl #(.STEP_PERIOD(STEP), .ZERO_RUN(RUN)) uut (
    .clk(clk), .rst_n(rst_n), .fs_tick(fs_tick), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_load(wr_load), .wr_code(wr_code),
    .common_en(common_en), .mute_n(mute_n), .mute_bit(mute_bit),
    .zdet_en(zdet_en), .zero_l(zero_l), .zero_r(zero_r),
    .gain_l(gain_l), .gain_r(gain_r), .auto_mute(auto_mute)
  );

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic ticks(input int n, input logic zl, input logic zr);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      fs_tick = 1'b1; zero_l = zl; zero_r = zr;
      @(negedge clk);
      fs_tick = 1'b0; zero_l = 1'b0; zero_r = 1'b0;
    end
  endtask

  task automatic write(input logic sel, input logic [7:0] code, input logic ld);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_code = code; wr_load = ld;
    @(negedge clk);
    wr_en = 1'b0; wr_load = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "gain_l", gain_l, 8'hFF);
    chk("R1", "gain_r", gain_r, 8'hFF);
    chk("R1", "auto_mute", {7'd0, auto_mute}, 8'h00);
  endtask

  task automatic t_staged_and_load;
    write(1'b0, 8'hF0, 1'b0);
    ticks(3 * STEP, 1'b0, 1'b0);
    chk("R2", "gain_l unloaded", gain_l, 8'hFF);
    chk("R2", "gain_r unloaded", gain_r, 8'hFF);
    write(1'b1, 8'hF8, 1'b1);
    ticks(STEP - 1, 1'b0, 1'b0);
    chk("R5", "gain_l before first step", gain_l, 8'hFF);
    ticks(1, 1'b0, 1'b0);
    chk("R5", "gain_l first step", gain_l, 8'hFE);
    chk("R3", "gain_r first step", gain_r, 8'hFE);
    ticks(6 * STEP, 1'b0, 1'b0);
    chk("R3", "gain_r at target", gain_r, 8'hF8);
    ticks(8 * STEP, 1'b0, 1'b0);
    chk("R3", "gain_l at target", gain_l, 8'hF0);
    chk("R5", "gain_r holds", gain_r, 8'hF8);
  endtask

  task automatic t_common;
    @(negedge clk) common_en = 1'b1;
    ticks(8 * STEP, 1'b0, 1'b0);
    chk("R4", "gain_r follows left", gain_r, 8'hF0);
    write(1'b1, 8'h80, 1'b1);
    ticks(3 * STEP, 1'b0, 1'b0);
    chk("R4", "right setting ignored", gain_r, 8'hF0);
    write(1'b1, 8'hF0, 1'b1);
    @(negedge clk) common_en = 1'b0;
    ticks(2 * STEP, 1'b0, 1'b0);
    chk("R4", "gain_r after common off", gain_r, 8'hF0);
  endtask

  task automatic t_pin_mute;
    @(negedge clk) mute_n = 1'b0;
    ticks(2 * STEP, 1'b0, 1'b0);
    chk("R6", "gain_l two steps down", gain_l, 8'hEE);
    ticks(238 * STEP, 1'b0, 1'b0);
    chk("R6", "gain_l silent", gain_l, 8'h00);
    chk("R6", "gain_r silent", gain_r, 8'h00);
    ticks(2 * STEP, 1'b0, 1'b0);
    chk("R6", "gain_l holds silent", gain_l, 8'h00);
    @(negedge clk) mute_n = 1'b1;
    ticks(STEP, 1'b0, 1'b0);
    chk("R7", "gain_l first step up", gain_l, 8'h01);
    ticks(239 * STEP, 1'b0, 1'b0);
    chk("R7", "gain_l restored", gain_l, 8'hF0);
    chk("R7", "gain_r restored", gain_r, 8'hF0);
  endtask

  task automatic t_reverse;
    @(negedge clk) mute_bit = 1'b1;
    ticks(2 * STEP, 1'b0, 1'b0);
    chk("R6", "bit mute two steps", gain_r, 8'hEE);
    @(negedge clk) mute_bit = 1'b0;
    ticks(STEP - 1, 1'b0, 1'b0);
    chk("R8", "no step before period", gain_r, 8'hEE);
    ticks(1, 1'b0, 1'b0);
    chk("R8", "reversed one step", gain_r, 8'hEF);
    ticks(STEP, 1'b0, 1'b0);
    chk("R8", "back at target", gain_l, 8'hF0);
  endtask

  task automatic t_automute;
    @(negedge clk) zdet_en = 1'b1;
    ticks(RUN - 1, 1'b1, 1'b1);
    chk("R9", "one short of run", {7'd0, auto_mute}, 8'h00);
    ticks(1, 1'b1, 1'b1);
    chk("R9", "run complete", {7'd0, auto_mute}, 8'h01);
    chk("R11", "gain_l untouched", gain_l, 8'hF0);
    chk("R11", "gain_r untouched", gain_r, 8'hF0);
    ticks(1, 1'b0, 1'b1);
    chk("R10", "released by nonzero", {7'd0, auto_mute}, 8'h00);
    ticks(RUN + 2, 1'b1, 1'b0);
    chk("R9", "one channel zero only", {7'd0, auto_mute}, 8'h00);
    @(negedge clk) zdet_en = 1'b0;
    ticks(RUN + 2, 1'b1, 1'b1);
    chk("R9", "disabled", {7'd0, auto_mute}, 8'h00);
    chk("R11", "gain_l after run", gain_l, 8'hF0);
  endtask

  initial begin
    rst_n = 1'b0; fs_tick = 1'b0; wr_en = 1'b0; wr_sel = 1'b0;
    wr_load = 1'b0; wr_code = 8'h00; common_en = 1'b0; mute_n = 1'b1;
    mute_bit = 1'b0; zdet_en = 1'b0; zero_l = 1'b0; zero_r = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_staged_and_load();
    t_common();
    t_pin_mute();
    t_reverse();
    t_automute();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule